// File: doc/BRIEF.md
# Sectored Flash Program/Erase Controller

This block sits between a simple parallel processor bus and a behavioural flash array made of a main bank of 8 equal sectors and a boot bank of 4 equal sectors. Each sector has its own one-hot select input, and the low address bits pick the word inside the selected sector. Ordinary bus reads return array words. Bus writes never touch the array directly. A write only has an effect when it is part of a recognised command sequence, built from two unlock writes followed by a command byte.

A program clears bits in one word. An erase sets every word of one sector back to all ones. Each operation runs for a parameterised number of cycles. During that time `ready_o` is low and bus reads return a status word whose toggle bit flips on every read. A sector erase can be paused so that other sectors can be read, and then resumed. A further command switches reads to an identification mode, which returns the device identifier or the protection bit of the selected sector.

Top module: `flash_seq_ctrl`

## Requirements
- R1: Sector index i is 0..7 for `main_sel_i[i]` and 8..11 for `boot_sel_i[i-8]`. `addr_i[1:0]` picks the word inside the sector. A read with no select raised gives no `rdata_vld_o`, and a write with no select is ignored.
- R2: If `prot_i[i]` is set, a program or erase aimed at sector i leaves the array unchanged and `ready_o` stays 1.
- R3: The program sequence is 0xAA at address 0x555, then 0x55 at 0x2AA, then 0xA0 at 0x555, then a data write to the target word. The target word becomes old AND data. `ready_o` is 0 for exactly PROG_CYC cycles, starting the cycle after the data write.
- R4: The erase sequence is 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at any address of the target sector. Every word of that sector then reads 0xFFFF. `ready_o` is 0 for ERASE_CYC cycles.
- R5: A plain write, or a sequence with any mismatching step, leaves the array unchanged, keeps `ready_o` at 1, and returns the controller to read mode.
- R6: A write of 0xB0 during an erase pauses it and sets `ready_o` to 1 from the next cycle. While the erase is paused, reads of other sectors return array data. A write of 0x30 resumes the erase. The total number of low `ready_o` cycles is still ERASE_CYC.
- R7: While an operation runs, `ready_o` is 0 and every read returns a status word. In that word bit 6 inverts from one read to the next and all other bits are 0. After the operation completes, reads return array data.
- R8: After 0xAA@0x555, 0x55@0x2AA, 0x90@0x555, a read at word offset 0 returns DEV_ID. A read at offset 1 returns the protect bit of the selected sector in bit 0. Reads at other offsets return 0. A write of 0xF0 while idle restores array reads.
- R9: `rdata_o` and `rdata_vld_o` are registered. They are valid for one cycle, in the cycle after the edge that samples `rd_i`.
- R10: After reset, `ready_o` is 1, `rdata_vld_o` is 0, and every word reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_sel_i | input | 8 | One-hot select for the main-bank sectors |
| boot_sel_i | input | 4 | One-hot select for the boot-bank sectors |
| prot_i | input | 12 | Protect bit per sector, in sector index order |
| wr_i | input | 1 | Bus write strobe |
| rd_i | input | 1 | Bus read strobe |
| addr_i | input | 12 | Bus address; the low bits select the word |
| wdata_i | input | 16 | Write data; bits 7:0 carry command bytes |
| rdata_o | output | 16 | Read data |
| rdata_vld_o | output | 1 | Read data valid |
| ready_o | output | 1 | 1 when idle or paused, 0 while an operation runs |

## Verification
Read data is due in the cycle after the edge that samples `rd_i`. The bench therefore drives each strobe at a falling edge and samples one falling edge later. `ready_o` falls in the cycle after the final write of a sequence and stays low for exactly PROG_CYC or ERASE_CYC cycles, excluding any cycles spent paused. A monitor counts the low cycles at falling edges, and the bench compares that count with the parameter once `ready_o` returns high. Array contents are checked only after completion, against a model that ANDs program data into each word and sets erased sectors to all ones.

// File: rtl/flash_pkg.sv
package flash_pkg;
  typedef enum logic [2:0] {
    ST_RD, ST_U1, ST_U2, ST_PGM, ST_EU0, ST_EU1, ST_EU2
  } cmd_st_e;

  typedef enum logic {OP_PROG, OP_ERASE} op_e;

  localparam logic [7:0] CB_UNL1  = 8'hAA;
  localparam logic [7:0] CB_UNL2  = 8'h55;
  localparam logic [7:0] CB_PROG  = 8'hA0;
  localparam logic [7:0] CB_ERASE = 8'h80;
  localparam logic [7:0] CB_CONF  = 8'h30;
  localparam logic [7:0] CB_SUSP  = 8'hB0;
  localparam logic [7:0] CB_IDRD  = 8'h90;
  localparam logic [7:0] CB_RESET = 8'hF0;
  localparam int unsigned UNL_ADDR1 = 32'h555;
  localparam int unsigned UNL_ADDR2 = 32'h2AA;
  localparam int unsigned TOG_BIT   = 6;
endpackage

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cmd_i,
  input  logic              tgt_prot_i,
  input  logic              run_i,
  input  logic              erase_run_i,
  input  logic              susp_i,
  output logic              start_prog_o,
  output logic              start_erase_o,
  output logic              susp_req_o,
  output logic              resume_req_o,
  output logic              id_mode_o
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_ADDR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_ADDR2);

  cmd_st_e st_q, st_d;
  logic id_q, id_set, id_clr;
  logic unl1, unl2, at_a1;

  assign at_a1 = (addr_i == A1);
  assign unl1  = at_a1 && cmd_i == CB_UNL1;
  assign unl2  = (addr_i == A2) && cmd_i == CB_UNL2;

  always_comb begin
    st_d          = st_q;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    susp_req_o    = 1'b0;
    resume_req_o  = 1'b0;
    id_set        = 1'b0;
    id_clr        = 1'b0;
    if (wr_i) begin
      st_d = ST_RD;
      if (run_i || susp_i) begin
        susp_req_o   = erase_run_i && cmd_i == CB_SUSP;
        resume_req_o = susp_i && cmd_i == CB_CONF;
      end else begin
        unique case (st_q)
          ST_RD: begin
            if (unl1) st_d = ST_U1;
            id_clr = (cmd_i == CB_RESET);
          end
          ST_U1:  if (unl2) st_d = ST_U2;
          ST_U2: begin
            if (at_a1 && cmd_i == CB_PROG)       st_d = ST_PGM;
            else if (at_a1 && cmd_i == CB_ERASE) st_d = ST_EU0;
            else if (at_a1 && cmd_i == CB_IDRD)  id_set = 1'b1;
          end
          ST_PGM: start_prog_o = !tgt_prot_i;
          ST_EU0: if (unl1) st_d = ST_EU1;
          ST_EU1: if (unl2) st_d = ST_EU2;
          ST_EU2: start_erase_o = (cmd_i == CB_CONF) && !tgt_prot_i;
          default: st_d = ST_RD;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_RD;
      id_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (id_set) id_q <= 1'b1;
      else if (id_clr || start_prog_o || start_erase_o) id_q <= 1'b0;
    end
  end

  assign id_mode_o = id_q;

  // ID mode is entered only through a bus write
  assert_id_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(id_q) |-> $past(wr_i));
  // no command is decoded while an operation holds the bus
  assert_busy_ignore_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i || susp_i) |-> !(start_prog_o || start_erase_o || id_set));
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer
  import flash_pkg::*;
#(
  parameter int SECT_W    = 4,
  parameter int OFF_W     = 2,
  parameter int DATA_W    = 16,
  parameter int PROG_CYC  = 5,
  parameter int ERASE_CYC = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_prog_i,
  input  logic              start_erase_i,
  input  logic              susp_req_i,
  input  logic              resume_req_i,
  input  logic [SECT_W-1:0] sect_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              active_o,
  output logic              susp_o,
  output op_e               kind_o,
  output logic [SECT_W-1:0] sect_o,
  output logic [OFF_W-1:0]  off_o,
  output logic [DATA_W-1:0] data_o,
  output logic              commit_o
);
  localparam int MAX_CYC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             active_q, susp_q;
  op_e              kind_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      susp_q   <= 1'b0;
      kind_q   <= OP_PROG;
      cnt_q    <= '0;
      sect_o   <= '0;
      off_o    <= '0;
      data_o   <= '0;
    end else if (start_prog_i || start_erase_i) begin
      active_q <= 1'b1;
      susp_q   <= 1'b0;
      kind_q   <= start_erase_i ? OP_ERASE : OP_PROG;
      cnt_q    <= start_erase_i ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
      sect_o   <= sect_i;
      off_o    <= off_i;
      data_o   <= data_i;
    end else if (active_q) begin
      if (susp_q) begin
        if (resume_req_i) susp_q <= 1'b0;
      end else if (cnt_q == '0) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (susp_req_i) susp_q <= 1'b1;
      end
    end
  end

  assign active_o = active_q;
  assign susp_o   = susp_q;
  assign kind_o   = kind_q;
  assign commit_o = active_q && !susp_q && cnt_q == '0;

  assert_start_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !active_q);
  assert_susp_erase_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_q |-> (active_q && kind_q == OP_ERASE));
  assert_susp_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_q && !start_prog_i && !start_erase_i) |=> $stable(cnt_q));
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q < CNT_W'(MAX_CYC)));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_pkg::*;
#(
  parameter int NSECT      = 12,
  parameter int SECT_WORDS = 4,
  parameter int DATA_W     = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          commit_i,
  input  op_e                           kind_i,
  input  logic [$clog2(NSECT)-1:0]      wr_sect_i,
  input  logic [$clog2(SECT_WORDS)-1:0] wr_off_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic [$clog2(NSECT)-1:0]      rd_sect_i,
  input  logic [$clog2(SECT_WORDS)-1:0] rd_off_i,
  output logic [DATA_W-1:0]             rd_word_o
);
  localparam int NWORDS = NSECT * SECT_WORDS;
  localparam int IDX_W  = $clog2(NWORDS);

  logic [DATA_W-1:0] mem [NWORDS];
  logic [IDX_W-1:0]  wr_base, rd_base, wr_idx;

  assign wr_base = IDX_W'(wr_sect_i) * IDX_W'(SECT_WORDS);
  assign rd_base = IDX_W'(rd_sect_i) * IDX_W'(SECT_WORDS);
  assign wr_idx  = wr_base + IDX_W'(wr_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NWORDS; i++) mem[IDX_W'(i)] <= '1;
    end else if (commit_i) begin
      if (kind_i == OP_ERASE) begin
        for (int w = 0; w < SECT_WORDS; w++) mem[wr_base + IDX_W'(w)] <= '1;
      end else begin
        mem[wr_idx] <= mem[wr_idx] & wr_data_i;
      end
    end
  end

  assign rd_word_o = mem[rd_base + IDX_W'(rd_off_i)];
endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_pkg::*;
#(
  parameter int          MAIN_SECT  = 8,
  parameter int          BOOT_SECT  = 4,
  parameter int          SECT_WORDS = 4,
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 16,
  parameter int          PROG_CYC   = 5,
  parameter int          ERASE_CYC  = 20,
  parameter logic [15:0] DEV_ID     = 16'h5E71
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [MAIN_SECT-1:0]       main_sel_i,
  input  logic [BOOT_SECT-1:0]       boot_sel_i,
  input  logic [MAIN_SECT+BOOT_SECT-1:0] prot_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rdata_vld_o,
  output logic                       ready_o
);
  localparam int NSECT  = MAIN_SECT + BOOT_SECT;
  localparam int SECT_W = $clog2(NSECT);
  localparam int OFF_W  = $clog2(SECT_WORDS);

  logic [NSECT-1:0]  sel;
  logic              any_sel, tgt_prot, wr_q;
  logic [SECT_W-1:0] sect;
  logic [OFF_W-1:0]  off;

  assign sel      = {boot_sel_i, main_sel_i};
  assign any_sel  = |sel;
  assign off      = addr_i[OFF_W-1:0];
  assign tgt_prot = prot_i[sect];
  assign wr_q     = wr_i && any_sel;

  always_comb begin
    sect = '0;
    for (int i = 0; i < NSECT; i++) if (sel[i]) sect = SECT_W'(i);
  end

  logic start_prog, start_erase, susp_req, resume_req, id_mode;
  logic active, susp, commit, run, erase_run;
  op_e  kind;
  logic [SECT_W-1:0] op_sect;
  logic [OFF_W-1:0]  op_off;
  logic [DATA_W-1:0] op_data, arr_word;

  assign run       = active && !susp;
  assign erase_run = run && kind == OP_ERASE;

  flash_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk_i, .rst_ni,
    .wr_i         (wr_q),
    .addr_i,
    .cmd_i        (wdata_i[7:0]),
    .tgt_prot_i   (tgt_prot),
    .run_i        (run),
    .erase_run_i  (erase_run),
    .susp_i       (susp),
    .start_prog_o (start_prog),
    .start_erase_o(start_erase),
    .susp_req_o   (susp_req),
    .resume_req_o (resume_req),
    .id_mode_o    (id_mode)
  );

  flash_op_timer #(
    .SECT_W(SECT_W), .OFF_W(OFF_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_timer (
    .clk_i, .rst_ni,
    .start_prog_i (start_prog),
    .start_erase_i(start_erase),
    .susp_req_i   (susp_req),
    .resume_req_i (resume_req),
    .sect_i       (sect),
    .off_i        (off),
    .data_i       (wdata_i),
    .active_o     (active),
    .susp_o       (susp),
    .kind_o       (kind),
    .sect_o       (op_sect),
    .off_o        (op_off),
    .data_o       (op_data),
    .commit_o     (commit)
  );

  flash_array #(.NSECT(NSECT), .SECT_WORDS(SECT_WORDS), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .commit_i (commit),
    .kind_i   (kind),
    .wr_sect_i(op_sect),
    .wr_off_i (op_off),
    .wr_data_i(op_data),
    .rd_sect_i(sect),
    .rd_off_i (off),
    .rd_word_o(arr_word)
  );

  logic [DATA_W-1:0] status_w, id_w;
  logic              tog_q;

  always_comb begin
    status_w          = '0;
    status_w[TOG_BIT] = tog_q;
    id_w              = '0;
    if (off == '0)             id_w = DATA_W'(DEV_ID);
    else if (off == OFF_W'(1)) id_w[0] = tgt_prot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o     <= '0;
      rdata_vld_o <= 1'b0;
      tog_q       <= 1'b0;
    end else begin
      rdata_vld_o <= rd_i && any_sel;
      if (rd_i && any_sel) begin
        if (run || (susp && sect == op_sect)) begin
          rdata_o <= status_w;
          if (run) tog_q <= ~tog_q;
        end else if (id_mode) begin
          rdata_o <= id_w;
        end else begin
          rdata_o <= arr_word;
        end
      end
    end
  end

  assign ready_o = !run;

  assert_sel_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel));
  assert_no_prot_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog || start_erase) |-> !prot_i[sect]);
  assert_busy_after_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog || start_erase) |=> !ready_o);
  assert_ready_on_susp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req |=> ready_o);
  assert_vld_follows_rd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_vld_o |-> $past(rd_i));
endmodule

// File: tb/tb_flash_seq_ctrl.sv
`timescale 1ns/1ps
module tb_flash_seq_ctrl;
  localparam int PROG_CYC  = 5;
  localparam int ERASE_CYC = 20;
  localparam logic [15:0] DEV_ID = 16'h5E71;
  localparam logic [11:0] PROT = 12'h204;  // sectors 2 and 9

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] main_sel = '0;
  logic [3:0] boot_sel = '0;
  logic wr = 1'b0, rd = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic rvld, ready;

  always #2 clk = ~clk;

  flash_seq_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .DEV_ID(DEV_ID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .main_sel_i(main_sel), .boot_sel_i(boot_sel),
    .prot_i(PROT), .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_vld_o(rvld), .ready_o(ready)
  );

  int n_chk = 0, n_fail = 0, busy_negs = 0;
  logic [15:0] mdl [48];

  always @(negedge clk) if (rst_n && !ready) busy_negs++;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_sel(int s);
    main_sel = (s < 8) ? 8'(1 << s) : 8'h0;
    boot_sel = (s >= 8) ? 4'(1 << (s - 8)) : 4'h0;
  endtask

  task automatic do_wr(int s, logic [11:0] a, logic [15:0] d);
    @(negedge clk); set_sel(s); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0; main_sel = '0; boot_sel = '0;
  endtask

  task automatic do_rd(int s, int o, output logic [15:0] d, output logic v);
    @(negedge clk); set_sel(s); addr = 12'(o); rd = 1'b1;
    @(negedge clk); d = rdata; v = rvld; rd = 1'b0; main_sel = '0; boot_sel = '0;
  endtask

  task automatic do_prog(int s, int o, logic [15:0] d);
    do_wr(s, 12'h555, 16'h00AA); do_wr(s, 12'h2AA, 16'h0055);
    do_wr(s, 12'h555, 16'h00A0); do_wr(s, 12'(o), d);
  endtask

  task automatic do_erase(int s);
    do_wr(s, 12'h555, 16'h00AA); do_wr(s, 12'h2AA, 16'h0055);
    do_wr(s, 12'h555, 16'h0080); do_wr(s, 12'h555, 16'h00AA);
    do_wr(s, 12'h2AA, 16'h0055); do_wr(s, 12'h003, 16'h0030);
  endtask

  task automatic wait_ready();
    for (int n = 0; n < 1000 && !ready; n++) @(negedge clk);
  endtask

  task automatic read_all(string tag);
    logic [15:0] d; logic v;
    for (int s = 0; s < 12; s++)
      for (int o = 0; o < 4; o++) begin
        do_rd(s, o, d, v);
        chk({tag, " word"}, d, mdl[s*4+o]);
        chk("R9 valid", v, 1);
      end
  endtask

  function automatic logic [15:0] pat(int s, int o);
    return 16'((s * 16'h1357 + o * 16'h0241) ^ 16'h5A5A);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, d2; logic v; int b0;
    for (int i = 0; i < 48; i++) mdl[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 ready", ready, 1);
    chk("R10 vld", rvld, 0);
    read_all("R10");

    // R1: read with no select
    @(negedge clk); rd = 1'b1; addr = 12'h001;
    @(negedge clk); chk("R1 no-select vld", rvld, 0); rd = 1'b0;

    // R5: plain writes and a broken sequence
    b0 = busy_negs;
    for (int s = 0; s < 12; s++) do_wr(s, 12'h001, 16'h0000);
    do_wr(0, 12'h555, 16'h00AA); do_wr(0, 12'h123, 16'h0055);
    do_wr(0, 12'h555, 16'h00A0); do_wr(0, 12'h001, 16'h0000);
    chk("R5 busy", busy_negs - b0, 0);
    read_all("R5");

    // R3/R2: two program passes over every word
    for (int pass = 0; pass < 2; pass++)
      for (int s = 0; s < 12; s++)
        for (int o = 0; o < 4; o++) begin
          d = pass == 0 ? pat(s, o) : ~pat(s + 3, o + 1);
          b0 = busy_negs;
          do_prog(s, o, d);
          wait_ready();
          if (PROT[s]) chk("R2 prog busy", busy_negs - b0, 0);
          else begin
            chk("R3 prog busy", busy_negs - b0, PROG_CYC);
            mdl[s*4+o] = mdl[s*4+o] & d;
          end
        end
    read_all("R3 R2");

    // R7: status reads during an erase
    b0 = busy_negs;
    do_erase(1);
    chk("R7 ready low", ready, 0);
    do_rd(1, 0, d, v); do_rd(4, 2, d2, v);
    chk("R7 status other bits", {d & 16'hFFBF, d2 & 16'hFFBF}, 0);
    chk("R7 toggle", d[6] ^ d2[6], 1);
    wait_ready();
    chk("R4 erase busy", busy_negs - b0, ERASE_CYC);
    for (int o = 0; o < 4; o++) mdl[4+o] = 16'hFFFF;

    // R4/R2: erase sweep
    for (int s = 0; s < 12; s++) begin
      b0 = busy_negs;
      do_erase(s);
      wait_ready();
      if (PROT[s]) chk("R2 erase busy", busy_negs - b0, 0);
      else begin
        chk("R4 erase busy", busy_negs - b0, ERASE_CYC);
        for (int o = 0; o < 4; o++) mdl[s*4+o] = 16'hFFFF;
      end
    end
    read_all("R4 R2 R7");

    // R6: suspend and resume
    for (int o = 0; o < 4; o++) begin
      do_prog(5, o, pat(7, o)); wait_ready(); mdl[20+o] &= pat(7, o);
    end
    do_prog(0, 2, 16'h0F0F); wait_ready(); mdl[2] &= 16'h0F0F;
    b0 = busy_negs;
    do_erase(0);
    repeat (4) @(negedge clk);
    do_wr(7, 12'h000, 16'h00B0);
    chk("R6 ready on suspend", ready, 1);
    for (int o = 0; o < 4; o++) begin
      do_rd(5, o, d, v);
      chk("R6 read other sector", d, mdl[20+o]);
    end
    chk("R6 still paused", ready, 1);
    do_wr(0, 12'h000, 16'h0030);
    chk("R6 resumed", ready, 0);
    wait_ready();
    chk("R6 total busy", busy_negs - b0, ERASE_CYC);
    for (int o = 0; o < 4; o++) begin
      do_rd(0, o, d, v);
      chk("R6 erased after resume", d, 16'hFFFF);
      mdl[o] = 16'hFFFF;
    end

    // R8: identification mode
    do_wr(3, 12'h555, 16'h00AA); do_wr(3, 12'h2AA, 16'h0055); do_wr(3, 12'h555, 16'h0090);
    do_rd(3, 0, d, v); chk("R8 id", d, DEV_ID);
    do_rd(2, 1, d, v); chk("R8 prot set", d, 1);
    do_rd(3, 1, d, v); chk("R8 prot clear", d, 0);
    do_rd(9, 1, d, v); chk("R8 boot prot", d, 1);
    do_rd(3, 2, d, v); chk("R8 other offset", d, 0);
    do_wr(3, 12'h000, 16'h00F0);
    do_rd(5, 0, d, v); chk("R8 exit", d, mdl[20]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule